// File: doc/BRIEF.md
# Three-Level Lag Multiply-Accumulate Cell

This cell computes one lag of a cross-correlation. On every clock it takes a 3-level sample from the delay line (the A side) and the current sample of the undelayed B stream. It multiplies the two and shifts the product up by one so that the value is never negative. It then accumulates that biased value into a wide counter. The counter does not take the 0/1/2 value directly. A single-bit modulo-2 stage absorbs the biased value, and only a wrap of that stage advances the counter. The counter therefore moves by at most one step per clock.

The integrate input frames an integration period. On the first clock with integrate high, the cell clears its modulo-2 stage and its counter. While integrate stays high, every clock that is not blanked is accumulated. When integrate drops, the count freezes. A valid flag then tells the readout logic that the dump value can be copied. A test control splits the counter into independent byte-wide lanes so that each lane can be exercised on its own.

Top module: `lag_mac_cell`

## Requirements
- R1: A sample code of 2'b11 on either input is treated exactly like a zero sample (code 2'b00). The legal codes are 2'b00 = 0, 2'b01 = +1 and 2'b10 = -1.
- R2: Over N accumulated clocks, a product of -1 (codes 01×10) adds nothing to the count. A product of 0 adds floor(N/2).
- R3: A product of +1 (codes 01×01 or 10×10) advances the count by exactly one per accumulated clock, and the count never advances by more than one in a clock.
- R4: A clock with blank_i high leaves the count unchanged, and accumulation resumes on the next clock with blank_i low.
- R5: While integ_i is low, dump_cnt holds its value whatever the sample and blank inputs do.
- R6: On the clock where integ_i is first seen high after being low, the count and the modulo-2 stage both clear to zero. The sample of that clock is not accumulated, even if blank_i is high at the time.
- R7: After reset, dump_cnt is 0 and dump_vld is 0. dump_vld goes to 1 one clock after integ_i falls and stays 1 until the next period starts, at which point it drops in the same clock the count clears.
- R8: With test_i high, the counter works as four independent 8-bit lanes. Each lane counts every prescaler wrap, and each lane wraps modulo 256 without carrying into the next lane.
- R9: With test_i low, the four lanes form one 32-bit binary counter. A carry passes from each byte into the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| a_smp | input | 2 | Delay-line sample, 3-level code |
| b_smp | input | 2 | Undelayed stream B sample, 3-level code |
| blank_i | input | 1 | High suppresses accumulation |
| integ_i | input | 1 | High frames an integration period |
| test_i | input | 1 | High splits the counter into 8-bit lanes |
| dump_cnt | output | 32 | Accumulated count, frozen while integ_i is low |
| dump_vld | output | 1 | Frozen count is ready to be transferred |

## Verification
Blanking can fall on the same clock as the start of a period, and also on the same clock as the end of a period. In both cases the clear and the freeze must win, and the blank must not corrupt the result. The bench provokes this by holding blank_i high on the start edge and again on the falling edge of integ_i, after a previous period has left a large count behind. It then expects a result that contains only the unblanked samples in between, and expects dump_vld to be low right after the start. Separate periods check that no prescaler state leaks across the clear: a leftover half-count must not turn one zero-product sample into a count.

// File: rtl/lag_mac_pkg.sv
package lag_mac_pkg;

    typedef enum logic [1:0] {
        SMP_ZERO = 2'b00,
        SMP_POS  = 2'b01,
        SMP_NEG  = 2'b10,
        SMP_BAD  = 2'b11
    } smp_code_e;

    typedef enum logic [1:0] {
        BP_LOW  = 2'd0,
        BP_MID  = 2'd1,
        BP_HIGH = 2'd2
    } bprod_e;

    typedef struct packed {
        logic nz;
        logic neg;
    } tri_val_t;

    function automatic tri_val_t decode_smp(input logic [1:0] code);
        tri_val_t v;
        case (smp_code_e'(code))
            SMP_POS: v = '{nz: 1'b1, neg: 1'b0};
            SMP_NEG: v = '{nz: 1'b1, neg: 1'b1};
            default: v = '{nz: 1'b0, neg: 1'b0};
        endcase
        return v;
    endfunction

    function automatic bprod_e biased_mul(input tri_val_t x, input tri_val_t y);
        if (!x.nz || !y.nz) return BP_MID;
        return (x.neg ^ y.neg) ? BP_LOW : BP_HIGH;
    endfunction

endpackage

// File: rtl/lag_mult.sv
module lag_mult
    import lag_mac_pkg::*;
(
    input  logic [1:0] a_code,
    input  logic [1:0] b_code,
    output bprod_e     bprod
);
    tri_val_t a_v;
    tri_val_t b_v;

    always_comb begin
        a_v   = decode_smp(a_code);
        b_v   = decode_smp(b_code);
        bprod = biased_mul(a_v, b_v);
    end
endmodule

// File: rtl/lag_prescale.sv
module lag_prescale
    import lag_mac_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   clr,
    input  logic   en,
    input  bprod_e bprod,
    output logic   wrap
);
    logic half_q;

    always_comb begin
        wrap = en && ((bprod == BP_HIGH) || ((bprod == BP_MID) && half_q));
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            half_q <= 1'b0;
        end else if (en) begin
            half_q <= half_q ^ (bprod == BP_MID);
        end
    end
endmodule

// File: rtl/lag_counter.sv
module lag_counter #(
    parameter int CNT_W  = 32,
    parameter int LANE_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    input  logic             split,
    output logic [CNT_W-1:0] cnt
);
    localparam int N_LANES = CNT_W / LANE_W;

    logic [N_LANES:0] chain;
    assign chain[0] = inc;

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_q;
        logic              lane_inc;

        assign chain[g+1] = chain[g] & (&lane_q);
        assign lane_inc   = split ? inc : chain[g];
        assign cnt[g*LANE_W +: LANE_W] = lane_q;

        always_ff @(posedge clk) begin
            if (rst || clr) begin
                lane_q <= '0;
            end else if (lane_inc) begin
                lane_q <= lane_q + LANE_W'(1);
            end
        end
    end
endmodule

// File: rtl/lag_mac_cell.sv
module lag_mac_cell
    import lag_mac_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int LANE_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       a_smp,
    input  logic [1:0]       b_smp,
    input  logic             blank_i,
    input  logic             integ_i,
    input  logic             test_i,
    output logic [CNT_W-1:0] dump_cnt,
    output logic             dump_vld
);
    logic   integ_q;
    logic   start;
    logic   run;
    logic   wrap;
    bprod_e bprod;

    always_comb begin
        start = integ_i && !integ_q;
        run   = integ_i && integ_q && !blank_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            integ_q  <= 1'b0;
            dump_vld <= 1'b0;
        end else begin
            integ_q <= integ_i;
            if (integ_i)      dump_vld <= 1'b0;
            else if (integ_q) dump_vld <= 1'b1;
        end
    end

    lag_mult u_mult (
        .a_code (a_smp),
        .b_code (b_smp),
        .bprod  (bprod)
    );

    lag_prescale u_pre (
        .clk   (clk),
        .rst   (rst),
        .clr   (start),
        .en    (run),
        .bprod (bprod),
        .wrap  (wrap)
    );

    lag_counter #(.CNT_W(CNT_W), .LANE_W(LANE_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr   (start),
        .inc   (wrap),
        .split (test_i),
        .cnt   (dump_cnt)
    );
endmodule

// File: rtl/lag_mac_cell_chk.sv
module lag_mac_cell_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             blank_i,
    input logic             integ_i,
    input logic             test_i,
    input logic [CNT_W-1:0] dump_cnt,
    input logic             dump_vld
);
    AST_HOLD_WHEN_LOW: assert property (@(posedge clk) disable iff (rst)
        !integ_i |=> $stable(dump_cnt)); // R5

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (integ_i && !$past(integ_i)) |=> (dump_cnt == '0 && !dump_vld)); // R6

    AST_BLANK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (blank_i && integ_i && $past(integ_i)) |=> $stable(dump_cnt)); // R4

    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
        (integ_i && $past(integ_i) && !test_i) |=>
        (dump_cnt == $past(dump_cnt) || dump_cnt == $past(dump_cnt) + CNT_W'(1))); // R3

    AST_VALID_STAYS: assert property (@(posedge clk) disable iff (rst)
        (dump_vld && !integ_i) |=> (dump_vld && $stable(dump_cnt))); // R7
endmodule

bind lag_mac_cell lag_mac_cell_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .blank_i  (blank_i),
    .integ_i  (integ_i),
    .test_i   (test_i),
    .dump_cnt (dump_cnt),
    .dump_vld (dump_vld)
);

// File: tb/lag_mac_cell_tb_top.sv
module lag_mac_cell_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  a_smp = 2'b00;
    logic [1:0]  b_smp = 2'b00;
    logic        blank_i = 1'b0;
    logic        integ_i = 1'b0;
    logic        test_i = 1'b0;
    logic [31:0] dump_cnt;
    logic        dump_vld;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    lag_mac_cell dut_i (
        .clk      (clk),
        .rst      (rst),
        .a_smp    (a_smp),
        .b_smp    (b_smp),
        .blank_i  (blank_i),
        .integ_i  (integ_i),
        .test_i   (test_i),
        .dump_cnt (dump_cnt),
        .dump_vld (dump_vld)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Start edge, n accumulated clocks, falling edge; blank optional on both edges
    // and on accumulated clocks [bl_from, bl_from+bl_len).
    task automatic run_period(input logic [1:0] a, input logic [1:0] b, input int n,
                              input int bl_from, input int bl_len, input logic bl_edges);
        @(negedge clk);
        integ_i = 1'b1; blank_i = bl_edges; a_smp = a; b_smp = b;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            blank_i = (i >= bl_from) && (i < bl_from + bl_len);
        end
        @(negedge clk);
        integ_i = 1'b0; blank_i = bl_edges;
        @(negedge clk);
        blank_i = 1'b0;
    endtask

    task automatic t_reset;
        check("R7 reset count", dump_cnt, 32'd0);
        check("R7 reset valid", {31'd0, dump_vld}, 32'd1 - 32'd1);
    endtask

    task automatic t_products;
        run_period(2'b01, 2'b01, 10, 0, 0, 1'b0);
        check("R3 +1 product per clock", dump_cnt, 32'd10);
        check("R7 valid after fall", {31'd0, dump_vld}, 32'd1);
        run_period(2'b10, 2'b10, 10, 0, 0, 1'b0);
        check("R3 -1x-1 product", dump_cnt, 32'd10);
        run_period(2'b01, 2'b10, 10, 0, 0, 1'b0);
        check("R2 -1 product", dump_cnt, 32'd0);
        run_period(2'b00, 2'b01, 10, 0, 0, 1'b0);
        check("R2 zero product even", dump_cnt, 32'd5);
        run_period(2'b00, 2'b00, 7, 0, 0, 1'b0);
        check("R2 zero product odd", dump_cnt, 32'd3);
        run_period(2'b11, 2'b01, 10, 0, 0, 1'b0);
        check("R1 illegal on A", dump_cnt, 32'd5);
        run_period(2'b10, 2'b11, 10, 0, 0, 1'b0);
        check("R1 illegal on B", dump_cnt, 32'd5);
    endtask

    task automatic t_blank;
        run_period(2'b01, 2'b01, 10, 3, 4, 1'b0);
        check("R4 blanked clocks skipped", dump_cnt, 32'd6);
    endtask

    task automatic t_freeze;
        run_period(2'b01, 2'b01, 7, 0, 0, 1'b0);
        a_smp = 2'b01; b_smp = 2'b01;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            blank_i = i[0];
        end
        blank_i = 1'b0;
        check("R5 frozen count", dump_cnt, 32'd7);
        check("R7 valid held", {31'd0, dump_vld}, 32'd1);
    endtask

    task automatic t_clear;
        run_period(2'b00, 2'b00, 3, 0, 0, 1'b0);
        check("R2 leaves half count", dump_cnt, 32'd1);
        run_period(2'b00, 2'b00, 1, 0, 0, 1'b0);
        check("R6 prescaler cleared", dump_cnt, 32'd0);
        run_period(2'b01, 2'b01, 9, 0, 0, 1'b0);
        @(negedge clk);
        integ_i = 1'b1;
        @(negedge clk);
        check("R6 count cleared at start", dump_cnt, 32'd0);
        check("R7 valid drops at start", {31'd0, dump_vld}, 32'd0);
        @(negedge clk);
        integ_i = 1'b0;
        @(negedge clk);
        check("R6 one clock accumulated", dump_cnt, 32'd1);
    endtask

    task automatic t_lanes;
        test_i = 1'b0;
        run_period(2'b01, 2'b01, 300, 0, 0, 1'b0);
        check("R9 carry across lanes", dump_cnt, 32'h0000_012C);
        test_i = 1'b1;
        run_period(2'b10, 2'b10, 300, 0, 0, 1'b0);
        check("R8 split lanes wrap", dump_cnt, 32'h2C2C_2C2C);
        test_i = 1'b0;
    endtask

    task automatic t_overlap;
        run_period(2'b01, 2'b01, 4, 0, 0, 1'b1);
        check("R4 R6 blank on both edges", dump_cnt, 32'd4);
        check("R7 valid after blanked fall", {31'd0, dump_vld}, 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_products();
        t_blank();
        t_freeze();
        t_clear();
        t_lanes();
        t_overlap();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule